// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block moves a single 36-bit word from a writer running on clock B to a reader running on clock A. A B-side mailbox write loads the word into a holding register and pulls the active-low B-side flag low. From then on, further B-side writes are refused and the held word is kept. The A side sees its own active-low indication fall once the news has crossed the clock boundary. An A-side mailbox read returns the word and clears the A-side indication. The B-side flag rises again once the consumption has crossed back.

The two domains never share a level signal directly. Each side owns a toggle bit: the B side flips its request toggle on an accepted write, and the A side flips its acknowledge toggle on a consuming read. Each toggle reaches the other side through a two-flop synchronizer. The held word is loaded in the B domain and stays stable for the whole time the A side may sample it.

The writer FSM has two states. `WR_EMPTY` moves to `WR_HELD` on an accepted write, and `WR_HELD` moves back to `WR_EMPTY` once the synchronized acknowledge equals the request toggle. The reader FSM also has two states. `RD_IDLE` moves to `RD_AVAIL` when the synchronized request differs from the acknowledge toggle, and `RD_AVAIL` moves back to `RD_IDLE` on an accepted mailbox read.

Top module: `mbx_xclk`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `b_full_n` and `a_full_n` are 1 and `a_dout` is 0. Asserting reset with a word held clears it.
- R2: A B-side mailbox write is accepted when, at a rising `clk_b` edge, `b_sel_n`=0, `b_en`=1, `b_wr`=1, `b_mbx`=1 and `b_full_n`=1. After that edge `b_full_n` is 0.
- R3: While `b_full_n` is 0, B-side writes are ignored. The held word is preserved, and the next A-side read returns the first word.
- R4: After an accepted B write, `a_full_n` goes low within 3 rising edges of `clk_a`.
- R5: An A-side mailbox read is accepted when, at a rising `clk_a` edge, `a_sel_n`=0, `a_en`=1, `a_wr`=0, `a_mbx`=1 and `a_full_n`=0. After that edge `a_dout` holds the written word and `a_full_n` is 1.
- R6: After an accepted A read, `b_full_n` returns to 1 within 4 rising edges of `clk_b`.
- R7: An access on either side has no effect on the flags or on the held or output word if any of these is true: `sel_n`=1, `en`=0, `mbx`=0, or the direction is opposite to the one the side serves.
- R8: An A-side mailbox read while `a_full_n` is 1 leaves `a_dout` unchanged, and the flags stay unchanged.
- R9: `a_oe` is 1 exactly when `a_wr` is 0, and `b_oe` is 1 exactly when `b_wr` is 0. A value of 1 means the port's data outputs are driven.
- R10: A sequence of words written and read one at a time with unrelated clocks arrives complete and in order, with no word lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reader-side clock |
| clk_b | input | 1 | Writer-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_sel_n | input | 1 | A-side chip select, active low |
| a_en | input | 1 | A-side access enable |
| a_wr | input | 1 | A-side direction: 1 write, 0 read |
| a_mbx | input | 1 | A-side mailbox select |
| a_dout | output | 36 | Word returned by the last consuming read |
| a_oe | output | 1 | A-side data output enable |
| a_full_n | output | 1 | A-side view of the mailbox, low while a word waits |
| b_sel_n | input | 1 | B-side chip select, active low |
| b_en | input | 1 | B-side access enable |
| b_wr | input | 1 | B-side direction: 1 write, 0 read |
| b_mbx | input | 1 | B-side mailbox select |
| b_din | input | 36 | Word to deposit |
| b_oe | output | 1 | B-side data output enable |
| b_full_n | output | 1 | B-side flag, low while the mailbox is occupied |

## Verification
The bench goes after overwrites attempted while the flag is low. A design that loaded the register regardless would hand the reader the second word instead of the first. It also tries every single wrong gating input on both sides. A design that dropped one term would raise a flag or consume a word on a stray cycle. Reads of an empty mailbox are checked, because a design that loaded `a_dout` unconditionally would corrupt the last delivered word. Reset with a word pending is checked, because a design that missed clearing a toggle would leave a stale flag or report a phantom word after reset.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    typedef enum logic {
        WR_EMPTY = 1'b0,
        WR_HELD  = 1'b1
    } wr_state_t;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_AVAIL = 1'b1
    } rd_state_t;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
`timescale 1ns/1ps
module mbx_wr_side
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_sel_n,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic              ack_tog,
    output logic              req_tog,
    output logic [DATA_W-1:0] word_q,
    output logic              flag_n,
    output logic              b_oe
);
    wr_state_t state, nxt;
    logic      ack_s;
    logic      wr_hit;
    logic      take;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_b),
        .rst_n (rst_n),
        .d     (ack_tog),
        .q     (ack_s)
    );

    assign wr_hit = !b_sel_n && b_en && b_wr && b_mbx;
    assign take   = (state == WR_EMPTY) && wr_hit;

    always_comb begin
        nxt = state;
        unique case (state)
            WR_EMPTY: if (wr_hit)           nxt = WR_HELD;
            WR_HELD:  if (ack_s == req_tog) nxt = WR_EMPTY;
        endcase
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n)
            state <= WR_EMPTY;
        else
            state <= nxt;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            req_tog <= 1'b0;
            word_q  <= '0;
        end else if (take) begin
            req_tog <= ~req_tog;
            word_q  <= b_din;
        end
    end

    assign flag_n = (state == WR_EMPTY);
    assign b_oe   = !b_wr;
endmodule

// File: rtl/mbx_rd_side.sv
`timescale 1ns/1ps
module mbx_rd_side
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbx,
    input  logic              req_tog,
    input  logic [DATA_W-1:0] word_in,
    output logic              ack_tog,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_full_n,
    output logic              a_oe
);
    rd_state_t state, nxt;
    logic      req_s;
    logic      rd_hit;
    logic      take;

    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_a),
        .rst_n (rst_n),
        .d     (req_tog),
        .q     (req_s)
    );

    assign rd_hit = !a_sel_n && a_en && !a_wr && a_mbx;
    assign take   = (state == RD_AVAIL) && rd_hit;

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  if (req_s != ack_tog) nxt = RD_AVAIL;
            RD_AVAIL: if (rd_hit)           nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n)
            state <= RD_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            ack_tog <= 1'b0;
            a_dout  <= '0;
        end else if (take) begin
            ack_tog <= ~ack_tog;
            a_dout  <= word_in;
        end
    end

    assign a_full_n = (state == RD_IDLE);
    assign a_oe     = !a_wr;
endmodule

// File: rtl/mbx_xclk.sv
`timescale 1ns/1ps
module mbx_xclk #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_en,
    input  logic              a_wr,
    input  logic              a_mbx,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_oe,
    output logic              a_full_n,
    input  logic              b_sel_n,
    input  logic              b_en,
    input  logic              b_wr,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    output logic              b_oe,
    output logic              b_full_n
);
    logic              req_tog;
    logic              ack_tog;
    logic [DATA_W-1:0] word_q;

    mbx_wr_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk_b   (clk_b),
        .rst_n   (rst_n),
        .b_sel_n (b_sel_n),
        .b_en    (b_en),
        .b_wr    (b_wr),
        .b_mbx   (b_mbx),
        .b_din   (b_din),
        .ack_tog (ack_tog),
        .req_tog (req_tog),
        .word_q  (word_q),
        .flag_n  (b_full_n),
        .b_oe    (b_oe)
    );

    mbx_rd_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk_a    (clk_a),
        .rst_n    (rst_n),
        .a_sel_n  (a_sel_n),
        .a_en     (a_en),
        .a_wr     (a_wr),
        .a_mbx    (a_mbx),
        .req_tog  (req_tog),
        .word_in  (word_q),
        .ack_tog  (ack_tog),
        .a_dout   (a_dout),
        .a_full_n (a_full_n),
        .a_oe     (a_oe)
    );
endmodule

// File: rtl/mbx_xclk_chk.sv
`timescale 1ns/1ps
module mbx_xclk_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic              a_sel_n,
    input logic              a_en,
    input logic              a_wr,
    input logic              a_mbx,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_full_n,
    input logic              b_sel_n,
    input logic              b_en,
    input logic              b_wr,
    input logic              b_mbx,
    input logic              b_full_n,
    input logic [DATA_W-1:0] word_q
);
    logic b_hit;
    logic a_hit;
    assign b_hit = !b_sel_n && b_en && b_wr && b_mbx;
    assign a_hit = !a_sel_n && a_en && !a_wr && a_mbx;

    p_flag_low_after_write_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_hit && b_full_n) |=> !b_full_n);

    p_hold_while_full_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        !b_full_n |=> $stable(word_q));

    p_reader_implies_writer_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_full_n |-> !b_full_n);

    p_read_clears_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_hit && !a_full_n) |=> a_full_n);

    p_dout_kept_when_empty_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_full_n |=> $stable(a_dout));
endmodule

bind mbx_xclk mbx_xclk_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .a_sel_n  (a_sel_n),
    .a_en     (a_en),
    .a_wr     (a_wr),
    .a_mbx    (a_mbx),
    .a_dout   (a_dout),
    .a_full_n (a_full_n),
    .b_sel_n  (b_sel_n),
    .b_en     (b_en),
    .b_wr     (b_wr),
    .b_mbx    (b_mbx),
    .b_full_n (b_full_n),
    .word_q   (word_q)
);

// File: tb/tb_mbx_xclk.sv
`timescale 1ns/1ps
module tb_mbx_xclk;
    localparam int W = 36;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b0;
    logic a_sel_n = 1'b1, a_en = 1'b0, a_wr = 1'b1, a_mbx = 1'b0;
    logic b_sel_n = 1'b1, b_en = 1'b0, b_wr = 1'b1, b_mbx = 1'b0;
    logic [W-1:0] b_din = '0;
    logic [W-1:0] a_dout;
    logic a_oe, a_full_n, b_oe, b_full_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4   clk_a = ~clk_a;
    always #6.5 clk_b = ~clk_b;

    mbx_xclk dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
        .a_dout(a_dout), .a_oe(a_oe), .a_full_n(a_full_n),
        .b_sel_n(b_sel_n), .b_en(b_en), .b_wr(b_wr), .b_mbx(b_mbx),
        .b_din(b_din), .b_oe(b_oe), .b_full_n(b_full_n)
    );

    // bit 36: attempt an overwrite while full; bits 35:0: word
    localparam logic [36:0] VEC [6] = '{
        {1'b0, 36'h0_0000_0001},
        {1'b1, 36'hA_5A5A_5A5A},
        {1'b0, 36'hF_FFFF_FFFF},
        {1'b1, 36'h0_0000_0000},
        {1'b0, 36'h1_2345_6789},
        {1'b1, 36'h8_0000_0001}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic b_access(input logic sn, input logic en, input logic wr, input logic mb, input logic [W-1:0] d);
        @(negedge clk_b);
        b_sel_n = sn; b_en = en; b_wr = wr; b_mbx = mb; b_din = d;
        @(negedge clk_b);
        b_sel_n = 1'b1; b_en = 1'b0; b_wr = 1'b1; b_mbx = 1'b0;
    endtask

    task automatic a_access(input logic sn, input logic en, input logic wr, input logic mb);
        @(negedge clk_a);
        a_sel_n = sn; a_en = en; a_wr = wr; a_mbx = mb;
        @(negedge clk_a);
        a_sel_n = 1'b1; a_en = 1'b0; a_wr = 1'b1; a_mbx = 1'b0;
    endtask

    task automatic wait_a_full(output int n);
        n = 0;
        while (a_full_n && n < 6) begin
            @(negedge clk_a);
            n++;
        end
    endtask

    task automatic wait_b_empty(output int n);
        n = 0;
        while (!b_full_n && n < 8) begin
            @(negedge clk_b);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [W-1:0] last;
        repeat (5) @(negedge clk_b);
        chk(b_full_n == 1'b1, "R1 b_full_n in reset", 64'(b_full_n), 64'd1);
        chk(a_full_n == 1'b1, "R1 a_full_n in reset", 64'(a_full_n), 64'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_a);
        chk(b_full_n && a_full_n, "R1 flags after reset", 64'({b_full_n, a_full_n}), 64'd3);
        chk(a_dout == '0, "R1 a_dout after reset", 64'(a_dout), 64'd0);

        // table walk
        foreach (VEC[i]) begin
            chk(b_full_n == 1'b1, "R6 flag high before write", 64'(b_full_n), 64'd1);
            b_access(1'b0, 1'b1, 1'b1, 1'b1, VEC[i][W-1:0]);
            chk(b_full_n == 1'b0, "R2 flag low after write", 64'(b_full_n), 64'd0);
            if (VEC[i][36]) begin
                b_access(1'b0, 1'b1, 1'b1, 1'b1, ~VEC[i][W-1:0]);
                chk(b_full_n == 1'b0, "R3 flag stays low on overwrite", 64'(b_full_n), 64'd0);
            end
            @(negedge clk_a);
            wait_a_full(n);
            chk(a_full_n == 1'b0 && n <= 3, "R4 a_full_n low in time", 64'(n), 64'd3);
            a_access(1'b0, 1'b1, 1'b0, 1'b1);
            chk(a_dout == VEC[i][W-1:0], "R10 R3 word delivered", 64'(a_dout), 64'(VEC[i][W-1:0]));
            chk(a_full_n == 1'b1, "R5 a_full_n high after read", 64'(a_full_n), 64'd1);
            wait_b_empty(n);
            chk(b_full_n == 1'b1 && n <= 4, "R6 b_full_n back high", 64'(n), 64'd4);
        end
        last = VEC[5][W-1:0];

        // R8: read of empty mailbox
        a_access(1'b0, 1'b1, 1'b0, 1'b1);
        chk(a_dout == last, "R8 a_dout kept on empty read", 64'(a_dout), 64'(last));
        chk(a_full_n && b_full_n, "R8 flags unchanged", 64'({b_full_n, a_full_n}), 64'd3);

        // R7: B-side gating, each wrong term alone
        b_access(1'b1, 1'b1, 1'b1, 1'b1, 36'h111);
        b_access(1'b0, 1'b0, 1'b1, 1'b1, 36'h222);
        b_access(1'b0, 1'b1, 1'b0, 1'b1, 36'h333);
        b_access(1'b0, 1'b1, 1'b1, 1'b0, 36'h444);
        repeat (8) @(negedge clk_a);
        chk(b_full_n == 1'b1, "R7 B gating keeps b_full_n", 64'(b_full_n), 64'd1);
        chk(a_full_n == 1'b1, "R7 B gating keeps a_full_n", 64'(a_full_n), 64'd1);

        // R7: A-side gating while a word waits
        b_access(1'b0, 1'b1, 1'b1, 1'b1, 36'h9_8765_4321);
        @(negedge clk_a);
        wait_a_full(n);
        chk(a_full_n == 1'b0, "R4 word pending", 64'(a_full_n), 64'd0);
        a_access(1'b1, 1'b1, 1'b0, 1'b1);
        a_access(1'b0, 1'b0, 1'b0, 1'b1);
        a_access(1'b0, 1'b1, 1'b1, 1'b1);
        a_access(1'b0, 1'b1, 1'b0, 1'b0);
        chk(a_full_n == 1'b0, "R7 A gating keeps a_full_n", 64'(a_full_n), 64'd0);
        chk(a_dout == last, "R7 A gating keeps a_dout", 64'(a_dout), 64'(last));
        a_access(1'b0, 1'b1, 1'b0, 1'b1);
        chk(a_dout == 36'h9_8765_4321, "R5 word after gated tries", 64'(a_dout), 64'h9_8765_4321);
        wait_b_empty(n);

        // R9: output enables
        @(negedge clk_a);
        a_wr = 1'b0; b_wr = 1'b0;
        #1;
        chk(a_oe && b_oe, "R9 oe high on read", 64'({a_oe, b_oe}), 64'd3);
        a_wr = 1'b1; b_wr = 1'b1;
        #1;
        chk(!a_oe && !b_oe, "R9 oe low on write", 64'({a_oe, b_oe}), 64'd0);

        // R1: reset with a word pending
        b_access(1'b0, 1'b1, 1'b1, 1'b1, 36'h5_5555_5555);
        @(negedge clk_a);
        wait_a_full(n);
        @(negedge clk_a);
        rst_n = 1'b0;
        repeat (4) @(negedge clk_b);
        rst_n = 1'b1;
        repeat (6) @(negedge clk_a);
        chk(a_full_n && b_full_n, "R1 flags after mid reset", 64'({b_full_n, a_full_n}), 64'd3);
        chk(a_dout == '0, "R1 a_dout after mid reset", 64'(a_dout), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule